// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of a parameterized width (four bits by default) using one full adder and one carry flip-flop. It works over several clock cycles instead of with a ripple of adders. A start pulse copies both operands into two shift registers and clears the carry. The block then runs exactly one add cycle per operand bit, least significant bit first.

In each add cycle the full adder combines the low bit of each register with the stored carry. The sum bit goes into the top of the first register, and both registers shift right. The second register fills with zeros from the top. When the last cycle is over, the first register holds the sum and the carry flip-flop holds the carry-out. A done flag then rises and stays high until the next start.

The carry flip-flop behaves as a JK stage. J is the AND of the two operand bits and K is the AND of their complements. With neither set, it holds its value. This makes its next value the majority of the two bits and the old carry.

Top module: `bitSerialAdder`

## Requirements
- R1: While reset is held and right after it, `sum` is 0, `carryOut` is 0 and `done` is 0.
- R2: A `start` sampled high while no add is in progress loads `opA` into `sum` and `opB` into the second register, and clears `carryOut` and `done` on that same edge.
- R3: The block runs exactly WIDTH add cycles after the load edge. `done` reads 0 after the load edge and after each of the first WIDTH-1 add edges, and reads 1 after the WIDTH-th add edge.
- R4: Once `done` is 1, `sum` equals (opA + opB) mod 2^WIDTH and `carryOut` equals bit WIDTH of opA + opB.
- R5: Bits go least significant first. After k add cycles, `sum >> (WIDTH-k)` equals the low k bits of opA + opB.
- R6: After k add cycles, `carryOut` equals the carry out of adding the low k bits of both operands. The flip-flop sets when both bits are 1, clears when both are 0, and otherwise holds.
- R7: A `start` sampled high during an add is ignored. The operation in progress completes with its original result and timing.
- R8: While `done` is 1 and `start` is low, `sum`, `carryOut` and `done` hold their values.
- R9: A `start` while `done` is 1 begins a new operation, and `carryOut` clears even if the previous result had a carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load operands and begin an add |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| sum | output | WIDTH | First shift register; holds the sum when done |
| carryOut | output | 1 | Carry flip-flop; holds the final carry when done |
| done | output | 1 | High once all add cycles have completed |

## Verification
The bench checks every add cycle, not only the final result. It compares the top bits of `sum` and the carry flip-flop against the partial sum of the low bits. A design that shifted in the wrong direction, or took bits most significant first, fails at the first cycle. A design with a swapped J/K would still produce correct sums whenever the carry never changes, so the all-ones and carry-chain cases are there to catch it.

An off-by-one counter shows up as `done` one cycle early or late. A design that does not clear the carry on load adds a stale 1 after an all-ones result. The bench also raises `start` in mid-run, which a design without the busy guard would obey, corrupting the result.

// File: rtl/bsaPkg.sv
package bsaPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic load;   // capture operands, clear carry
    logic shift;  // one add cycle
  } strobe_t;
endpackage

// File: rtl/fullAdderBit.sv
module fullAdderBit (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s
);
  assign s = x ^ y ^ cin;
endmodule

// File: rtl/jkCarry.sv
module jkCarry (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic enable,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      q <= 1'b0;
    end else if (enable) begin
      unique case ({j, k})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/bsaDatapath.sv
module bsaDatapath
  import bsaPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] regA,
  output logic [WIDTH-1:0] regB,
  output logic             carry
);
  logic xBit, yBit, sumBit;

  assign xBit = regA[0];
  assign yBit = regB[0];

  fullAdderBit fa_i (
    .x  (xBit),
    .y  (yBit),
    .cin(carry),
    .s  (sumBit)
  );

  jkCarry carry_i (
    .clk   (clk),
    .rstN  (rstN),
    .clear (strobe.load),
    .enable(strobe.shift),
    .j     (xBit & yBit),
    .k     (~xBit & ~yBit),
    .q     (carry)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else if (strobe.load) begin
      regA <= opA;
      regB <= opB;
    end else if (strobe.shift) begin
      regA <= {sumBit, regA[WIDTH-1:1]};
      regB <= {1'b0, regB[WIDTH-1:1]};
    end
  end
endmodule

// File: rtl/bsaControl.sv
module bsaControl
  import bsaPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t strobe,
  output logic    running,
  output logic    done
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  ctrlState_t state;
  logic [CNT_W-1:0] cycleCnt;

  assign running = (state == ST_RUN);
  assign done    = (state == ST_DONE);

  always_comb begin
    strobe       = '0;
    strobe.load  = start && (state != ST_RUN);
    strobe.shift = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cycleCnt <= '0;
    end else if (strobe.load) begin
      state    <= ST_RUN;
      cycleCnt <= '0;
    end else if (state == ST_RUN) begin
      if (cycleCnt == LAST) state <= ST_DONE;
      cycleCnt <= cycleCnt + 1'b1;
    end
  end
endmodule

// File: rtl/bitSerialAdder.sv
module bitSerialAdder
  import bsaPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             done
);
  strobe_t strobe;
  logic running;
  logic [WIDTH-1:0] bReg;

  bsaControl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .running(running),
    .done   (done)
  );

  bsaDatapath #(.WIDTH(WIDTH)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .regA  (sum),
    .regB  (bReg),
    .carry (carryOut)
  );
endmodule

// File: rtl/bitSerialAdderChk.sv
module bitSerialAdderChk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] sum,
  input logic             carryOut,
  input logic             done,
  input logic             running,
  input logic [WIDTH-1:0] bReg
);
  int chkCnt;

  always_ff @(posedge clk) begin
    if (!rstN) chkCnt <= 0;
    else if (start && !running) chkCnt <= 0;
    else if (running) chkCnt <= chkCnt + 1;
  end

  // R2
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    start && !running |=> (sum == $past(opA)) && !carryOut && !done);

  // R3
  p_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({running, done}));

  // R3
  p_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> chkCnt == WIDTH);

  // R5
  p_sum_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    running |=> sum[WIDTH-1] == ($past(sum[0]) ^ $past(bReg[0]) ^ $past(carryOut)));

  // R6
  p_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    running |=> carryOut == (($past(sum[0]) & $past(bReg[0])) |
                             ($past(sum[0]) & $past(carryOut)) |
                             ($past(bReg[0]) & $past(carryOut))));

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(sum) && $stable(carryOut));
endmodule

bind bitSerialAdder bitSerialAdderChk #(.WIDTH(WIDTH)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opA     (opA),
  .sum     (sum),
  .carryOut(carryOut),
  .done    (done),
  .running (running),
  .bReg    (bReg)
);

// File: tb/bitSerialAdder_tb_top.sv
`timescale 1ns/1ps
module bitSerialAdder_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [W-1:0] sum;
  logic carryOut, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bitSerialAdder #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .sum(sum), .carryOut(carryOut), .done(done)
  );

  function automatic logic [W:0] partialSum(logic [W-1:0] a, logic [W-1:0] b, int k);
    logic [W:0] m;
    m = (({{W{1'b0}}, 1'b1}) << k) - 1'b1;
    return ({1'b0, a} & m) + ({1'b0, b} & m);
  endfunction

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Full operation; if intrude, raise start with other operands in mid-run (R7)
  task automatic runOp(logic [W-1:0] a, logic [W-1:0] b, bit intrude);
    logic [W:0] p;
    @(negedge clk);
    start = 1'b1; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 sum", {1'b0, sum}, {1'b0, a});
    check("R2/R9 carry", {{W{1'b0}}, carryOut}, '0);
    check("R2 done", {{W{1'b0}}, done}, '0);
    for (int k = 1; k <= W; k++) begin
      if (intrude && k == 2) begin
        start = 1'b1; opA = ~a; opB = a ^ b;
      end
      @(negedge clk);
      start = 1'b0;
      p = partialSum(a, b, k);
      check(intrude ? "R7/R5 partial" : "R5 partial",
            {1'b0, sum >> (W - k)}, p & ((({{W{1'b0}}, 1'b1}) << k) - 1'b1));
      check("R6 carry", {{W{1'b0}}, carryOut}, {{W{1'b0}}, p[k]});
      check("R3 done", {{W{1'b0}}, done}, {{W{1'b0}}, (k == W)});
    end
    p = {1'b0, a} + {1'b0, b};
    check("R4 result", {carryOut, sum}, p);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hs; logic hc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 sum", {1'b0, sum}, '0);
    check("R1 carry/done", {{(W-1){1'b0}}, carryOut, done}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {{(W-1){1'b0}}, carryOut, done}, '0);

    runOp('1, '1, 1'b0);
    // R8: hold after done
    hs = sum; hc = carryOut;
    repeat (3) @(negedge clk);
    check("R8 hold", {hc, hs}, {carryOut, sum});
    check("R8 done", {{W{1'b0}}, done}, {{W{1'b0}}, 1'b1});
    // R9: restart after a carry-out of 1
    runOp('0, '0, 1'b0);
    runOp('1, {{(W-1){1'b0}}, 1'b1}, 1'b0);
    runOp({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0);
    runOp(W'(4'b0101), W'(4'b1010), 1'b0);
    runOp(W'(4'b0111), W'(4'b0011), 1'b1);
    for (int i = 0; i < 40; i++) begin
      runOp(W'($urandom), W'($urandom), ($urandom % 4) == 0);
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule